// File: doc/BRIEF.md
# Time-of-Day Oscillator Counter

This block keeps a free-running nanosecond clock for a precision-time subsystem. Every clock cycle a programmable fixed-point step, with 3 integer and 29 fractional bits, is added to an internal accumulator. The accumulator holds a 44-bit nanosecond count and a fractional tail. Software trims the clock frequency by changing the step, and it sets time by loading the three slices of the count one at a time.

Software reaches the block over a plain 32-bit word bus with four registers. A write or a read takes effect on the clock edge where its strobe is high. Read data is combinational from the current address and state. The upper byte is written through the second byte lane of the write data and read back from the first byte lane. The value read back is a snapshot that is taken whenever the middle slice is read, so a middle-then-upper read pair always belongs to one instant.

Control is a two-state machine. STOPPED is the state whenever the step register holds zero; in this state the count is frozen. COUNTING is the state whenever the step is nonzero; in this state the step is added on each edge. The transition STOPPED to COUNTING happens on the edge that writes a nonzero step. The transition COUNTING to STOPPED happens on the edge that writes a zero step. Reset enters COUNTING because the reset step is nonzero.

Top module: `tod_nco_counter`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is held, the nanosecond count, the fraction and the upper snapshot are zero, and the step register reads 0x80000000.
- R2: In COUNTING, each clock edge adds the step register to the 73-bit value {count[43:0], fraction[28:0]}. The step is treated as an unsigned number with 29 fractional bits.
- R3: The count wraps modulo 2^44. From 0xFFFFFFFFFFF with a step of 4.0 ns, the next value is 0x003.
- R4: Writing 0 to the step register (word 3) enters STOPPED. The count then holds its value until a nonzero step is written.
- R5: Word 0 (bus_addr 0) reads count[3:0] in bits [3:0], with zeros above. A write to word 0 loads count[3:0] from wdata[3:0] and clears the fraction.
- R6: Word 1 (bus_addr 1) reads and writes count[35:4] across all 32 bits.
- R7: A write to word 2 (bus_addr 2) loads count[43:36] from wdata[15:8]. The other bits of wdata have no effect.
- R8: Word 2 reads the upper snapshot in bits [7:0], with zeros above. The snapshot captures count[43:36] on each edge where word 1 is read, and it also takes the value of a word 2 write.
- R9: On an edge where a slice is written while counting, the written slice takes the written value. The other slices take their stepped values, including any carry.
- R10: Word 3 (bus_addr 3) reads back the step register as it was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (drives the snapshot capture) |
| bus_addr | input | 2 | Word index (byte offset bits [3:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
A slice load and the per-cycle step can fall on the same edge. The bench provokes this by writing the low, middle and upper slices while a fractional step is counting. A second collision is a middle-slice read that takes a snapshot on the same edge where the count carries into the upper byte. The bench provokes it by reading word 1 continuously across the carry. Both cases are judged against a behavioural model of the whole value that is updated on every edge, and the read data is compared on every cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic {
        RUN_STOPPED  = 1'b0,
        RUN_COUNTING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        REG_LOW = 2'd0,
        REG_MID = 2'd1,
        REG_UP  = 2'd2,
        REG_INC = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tod_nco_accum.sv
module tod_nco_accum
    import tod_pkg::*;
#(
    parameter int NS_W      = 44,
    parameter int FRAC_W    = 29,
    parameter int INC_W     = 32,
    parameter int LOW_W     = 4,
    parameter int MID_W     = 32,
    parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_low,
    input  logic                          ld_mid,
    input  logic                          ld_up,
    input  logic                          ld_inc,
    input  logic [LOW_W-1:0]              low_val,
    input  logic [MID_W-1:0]              mid_val,
    input  logic [NS_W-LOW_W-MID_W-1:0]   up_val,
    input  logic [INC_W-1:0]              inc_val,
    output logic [NS_W-1:0]               time_ns,
    output logic [INC_W-1:0]              inc_q
);
    localparam int UP_W  = NS_W - LOW_W - MID_W;
    localparam int ACC_W = NS_W + FRAC_W;
    localparam int LOW_LSB = FRAC_W;
    localparam int MID_LSB = FRAC_W + LOW_W;
    localparam int UP_LSB  = FRAC_W + LOW_W + MID_W;

    run_state_e         state_q, state_d;
    logic [ACC_W-1:0]   acc_q, acc_sum, acc_d;
    logic [INC_W-1:0]   inc_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= (INC_RESET != '0) ? RUN_COUNTING : RUN_STOPPED;
            acc_q   <= '0;
            inc_q   <= INC_RESET;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            inc_q   <= inc_d;
        end
    end

    // next state and datapath outputs
    always_comb begin
        inc_d   = ld_inc ? inc_val : inc_q;
        state_d = (inc_d != '0) ? RUN_COUNTING : RUN_STOPPED;
        unique case (state_q)
            RUN_COUNTING: acc_sum = acc_q + {{(ACC_W-INC_W){1'b0}}, inc_q};
            RUN_STOPPED:  acc_sum = acc_q;
            default:      acc_sum = acc_q;
        endcase
        acc_d = acc_sum;
        if (ld_low) begin
            acc_d[LOW_LSB +: LOW_W] = low_val;
            acc_d[FRAC_W-1:0]       = '0;
        end
        if (ld_mid) acc_d[MID_LSB +: MID_W] = mid_val;
        if (ld_up)  acc_d[UP_LSB +: UP_W]   = up_val;
    end

    assign time_ns = acc_q[ACC_W-1 -: NS_W];

    a_r4_state_matches_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_STOPPED) == (inc_q == '0));

    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_STOPPED && !ld_low && !ld_mid && !ld_up)
        |=> (time_ns == $past(time_ns)));

    a_r2_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_COUNTING && inc_q[INC_W-1:FRAC_W] != '0 &&
         !ld_low && !ld_mid && !ld_up)
        |=> (time_ns != $past(time_ns)));

    a_r7_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_up |=> (time_ns[NS_W-1 -: UP_W] == $past(up_val)));
endmodule

// File: rtl/tod_bus_if.sv
module tod_bus_if
    import tod_pkg::*;
#(
    parameter int NS_W    = 44,
    parameter int LOW_W   = 4,
    parameter int MID_W   = 32,
    parameter int INC_W   = 32,
    parameter int DATA_W  = 32,
    parameter int UP_LANE = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [1:0]                   bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NS_W-1:0]              time_ns,
    input  logic [INC_W-1:0]             inc_q,
    output logic                         ld_low,
    output logic                         ld_mid,
    output logic                         ld_up,
    output logic                         ld_inc,
    output logic [LOW_W-1:0]             low_val,
    output logic [MID_W-1:0]             mid_val,
    output logic [NS_W-LOW_W-MID_W-1:0]  up_val,
    output logic [INC_W-1:0]             inc_val,
    output logic [DATA_W-1:0]            bus_rdata
);
    localparam int UP_W   = NS_W - LOW_W - MID_W;
    localparam int N_REGS = 4;

    logic [N_REGS-1:0] wr_hit;
    logic [UP_W-1:0]   shadow_q;
    logic              rd_mid;

    for (genvar g = 0; g < N_REGS; g++) begin : g_dec
        assign wr_hit[g] = bus_wr && (bus_addr == 2'(g));
    end

    assign ld_low  = wr_hit[REG_LOW];
    assign ld_mid  = wr_hit[REG_MID];
    assign ld_up   = wr_hit[REG_UP];
    assign ld_inc  = wr_hit[REG_INC];
    assign low_val = bus_wdata[LOW_W-1:0];
    assign mid_val = bus_wdata[MID_W-1:0];
    assign up_val  = bus_wdata[UP_LANE +: UP_W];
    assign inc_val = bus_wdata[INC_W-1:0];
    assign rd_mid  = bus_rd && (bus_addr == REG_MID);

    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (ld_up)  shadow_q <= up_val;
        else if (rd_mid) shadow_q <= time_ns[NS_W-1 -: UP_W];
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_LOW: bus_rdata[LOW_W-1:0] = time_ns[LOW_W-1:0];
            REG_MID: bus_rdata[MID_W-1:0] = time_ns[LOW_W +: MID_W];
            REG_UP:  bus_rdata[UP_W-1:0]  = shadow_q;
            REG_INC: bus_rdata[INC_W-1:0] = inc_q;
            default: bus_rdata = '0;
        endcase
    end

    a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mid && !bus_wr) |=> (shadow_q == $past(time_ns[NS_W-1 -: UP_W])));

    a_r5_onehot_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_low, ld_mid, ld_up, ld_inc}));
endmodule

// File: rtl/tod_nco_counter.sv
module tod_nco_counter
    import tod_pkg::*;
#(
    parameter int NS_W    = 44,
    parameter int FRAC_W  = 29,
    parameter int INC_W   = 32,
    parameter int LOW_W   = 4,
    parameter int MID_W   = 32,
    parameter int DATA_W  = 32,
    parameter int UP_LANE = 8,
    parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int UP_W = NS_W - LOW_W - MID_W;

    logic              ld_low, ld_mid, ld_up, ld_inc;
    logic [LOW_W-1:0]  low_val;
    logic [MID_W-1:0]  mid_val;
    logic [UP_W-1:0]   up_val;
    logic [INC_W-1:0]  inc_val, inc_q;
    logic [NS_W-1:0]   time_ns;

    tod_bus_if #(
        .NS_W(NS_W), .LOW_W(LOW_W), .MID_W(MID_W), .INC_W(INC_W),
        .DATA_W(DATA_W), .UP_LANE(UP_LANE)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .time_ns(time_ns),
        .inc_q(inc_q), .ld_low(ld_low), .ld_mid(ld_mid), .ld_up(ld_up),
        .ld_inc(ld_inc), .low_val(low_val), .mid_val(mid_val),
        .up_val(up_val), .inc_val(inc_val), .bus_rdata(bus_rdata)
    );

    tod_nco_accum #(
        .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W), .LOW_W(LOW_W),
        .MID_W(MID_W), .INC_RESET(INC_RESET)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .ld_low(ld_low), .ld_mid(ld_mid),
        .ld_up(ld_up), .ld_inc(ld_inc), .low_val(low_val),
        .mid_val(mid_val), .up_val(up_val), .inc_val(inc_val),
        .time_ns(time_ns), .inc_q(inc_q)
    );
endmodule

// File: tb/sim_tod_nco_counter.sv
module sim_tod_nco_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string tag = "R2";

    // behavioural model: 44-bit ns count above a 29-bit fraction
    logic [72:0] m_acc;
    logic [31:0] m_inc;
    logic [7:0]  m_snap;

    tod_nco_counter u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc  = '0;
            m_inc  = 32'h8000_0000;
            m_snap = '0;
        end else begin
            logic [72:0] nxt;
            logic [43:0] ns_now;
            ns_now = m_acc[72:29];
            nxt = m_acc + {41'd0, m_inc};
            if (bus_rd && bus_addr == 2'd1 && !bus_wr) m_snap = ns_now[43:36];
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: begin nxt[32:29] = bus_wdata[3:0]; nxt[28:0] = '0; end
                    2'd1: nxt[64:33] = bus_wdata;
                    2'd2: begin nxt[72:65] = bus_wdata[15:8]; m_snap = bus_wdata[15:8]; end
                    default: m_inc = bus_wdata;
                endcase
            end
            m_acc = nxt;
        end
    end

    function automatic logic [31:0] expect_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {28'd0, m_acc[32:29]};
            2'd1:    return m_acc[64:33];
            2'd2:    return {24'd0, m_snap};
            default: return m_inc;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, bus_addr, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) check(tag, bus_rdata, expect_rd(bus_addr));
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int n);
        bus_rd = 1'b1; bus_addr = a;
        repeat (n) begin @(negedge clk); #1; end
        bus_rd = 1'b0;
    endtask

    initial begin
        // R1: values held during reset
        repeat (2) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a);
            #0.5;
            check("R1", bus_rdata, (a == 3) ? 32'h8000_0000 : 32'h0);
            @(negedge clk);
        end
        #1;
        rst_n = 1'b1;
        tag = "R2"; rd(2'd1, 12); rd(2'd0, 6);
        tag = "R10"; wr(2'd3, 32'h2ABC_DEF1); rd(2'd3, 2);
        tag = "R2"; rd(2'd0, 20); rd(2'd1, 10);
        // R4: stop and hold
        tag = "R4"; wr(2'd3, 32'h0); rd(2'd1, 8); rd(2'd0, 4); rd(2'd3, 2);
        // R5, R6, R7 while stopped
        tag = "R5"; wr(2'd0, 32'hFFFF_FFF9); rd(2'd0, 3);
        tag = "R6"; wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, 3);
        tag = "R7"; wr(2'd2, 32'hA5A5_3CA5); rd(2'd2, 3);
        // R8: snapshot through middle read, then upper read
        tag = "R8"; rd(2'd1, 1); rd(2'd2, 3);
        // R3: wrap from the top of the count
        tag = "R3";
        wr(2'd0, 32'hF); wr(2'd1, 32'hFFFF_FFFF); wr(2'd2, 32'h0000_FF00);
        rd(2'd1, 1); rd(2'd2, 1);
        wr(2'd3, 32'h8000_0000);
        rd(2'd0, 4); rd(2'd1, 3); rd(2'd2, 2);
        // R8: snapshot across a carry into the upper byte
        tag = "R8";
        wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, 6); rd(2'd2, 2);
        // R9: slice writes while counting with a fractional step
        tag = "R9";
        wr(2'd3, 32'h3123_4567);
        wr(2'd1, 32'h0000_0007); rd(2'd0, 2);
        wr(2'd0, 32'h5); rd(2'd1, 2);
        wr(2'd2, 32'h0000_1200); rd(2'd1, 1); rd(2'd2, 2);
        rd(2'd0, 10);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule